// File: doc/BRIEF.md
# I2C Register-File Target

This block is a target on a two-wire I2C bus that lets an external master reach a bank of sixteen 8-bit registers. A fast system clock samples SCL and SDA through two-flop synchronizers and finds their edges. From those edges the block recognises START and STOP bus conditions, shifts in bytes, and drives SDA through an open-drain style output-enable. It acknowledges bytes and sends read data this way.

The bus address is fixed at the 7-bit value 0011010. In a write transaction, the first byte after the device-select byte sets an internal register pointer. Every byte after that is stored at the pointer, and the pointer then steps forward. A read transaction returns the register the pointer names, with no address phase. Reading continues for as long as the master acknowledges. The pointer survives STOP and repeated START.

A local port gives the surrounding logic direct read and write access to the same registers. The system clock must run at least 8 times faster than SCL.

Top module: `i2ct_top`

## Requirements
- R1: After reset, sda_oe is 0, every register reads 0 on the local port, and the pointer is 0.
- R2: A falling SDA edge while SCL is high is a START and a rising one is a STOP. A STOP in the middle of a byte discards the partial byte, so no register changes.
- R3: The address byte is taken MSB first on SCL rising edges. If its upper 7 bits equal 0011010 (byte 0x34 for write, 0x35 for read, where bit 0 = 1 means read), SDA is pulled low during the ninth clock. Otherwise SDA stays released and later bytes get no acknowledge and have no effect until the next START.
- R4: In a write, the byte after the address byte loads the pointer from its low 4 bits, and that byte is acknowledged.
- R5: Each later write byte is stored at the pointer and acknowledged, and the pointer then increments. The pointer wraps from 15 to 0.
- R6: A read addressed with 0x35 sends the register at the current pointer MSB first, starting at the SCL falling edge that ends the acknowledge. The pointer is kept across STOP.
- R7: After each byte sent, the pointer increments. While the master acknowledges (SDA low in the ninth clock), the next register follows. After a master not-acknowledge, SDA stays released.
- R8: A repeated START restarts byte reception without changing the pointer.
- R9: lcl_rdata always shows the register selected by lcl_addr. A cycle with lcl_we high writes lcl_wdata to it. A bus write in the same cycle to the same register takes priority.
- R10: sda_oe changes only while the synchronised SCL is low, or as SDA is released on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| lcl_addr | input | 4 | Local register select |
| lcl_we | input | 1 | Local write strobe |
| lcl_wdata | input | 8 | Local write data |
| lcl_rdata | output | 8 | Register contents at lcl_addr |

## Verification
A wrong bit counter or phase shows up at the ninth clock of the very next byte, as a missing or misplaced acknowledge, or as a data bit read one position off. A pointer that loads, steps or wraps wrongly stays hidden until a later transaction. It appears only when a local read, or the next current-address read, returns a neighbouring register. For this reason the tests chain transactions that depend on the pointer left behind by the previous one. An address decode that fails to ignore the bus shows as a stray acknowledge, or a changed register, during the bytes after a mismatched address.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_PTR,
    PH_WR,
    PH_RD,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic lvl,
  output logic rise,
  output logic fall
);
  // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], line_i};
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/i2ct_regs.sv
module i2ct_regs #(
  parameter int NREG = 16,
  parameter int DW   = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          loc_we,
  input  logic [AW-1:0] loc_addr,
  input  logic [DW-1:0] loc_wdata,
  output logic [DW-1:0] loc_rdata
);
  logic [DW-1:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            mem[g] <= '0;
      else if (bus_we && bus_addr == AW'(g)) mem[g] <= bus_wdata;
      else if (loc_we && loc_addr == AW'(g)) mem[g] <= loc_wdata;
    end
  end

  assign bus_rdata = mem[bus_addr];
  assign loc_rdata = mem[loc_addr];
endmodule

// File: rtl/i2ct_fsm.sv
module i2ct_fsm
  import i2ct_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 16,
  parameter logic [DW-2:0] DEV_ADDR = 7'h1A,
  localparam int AW  = $clog2(NREG),
  localparam int CW  = $clog2(DW) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          sda_rise,
  input  logic          sda_fall,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] ptr,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          sda_drive
);
  phase_t        phase_q, phase_d;
  logic          in_ack_q, in_ack_d;
  logic [CW-1:0] bitcnt_q, bitcnt_d;
  logic [DW-1:0] shreg_q, shreg_d;
  logic [DW-1:0] txsh_q, txsh_d;
  logic [AW-1:0] ptr_q, ptr_d, ptr_inc;
  logic          drive_q, drive_d;
  logic          mack_q, mack_d;
  logic          start, stop;

  assign start   = scl_lvl & sda_fall;
  assign stop    = scl_lvl & sda_rise;
  assign ptr_inc = (ptr_q == AW'(NREG - 1)) ? '0 : ptr_q + 1'b1;

  always_comb begin
    phase_d  = phase_q;
    in_ack_d = in_ack_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    txsh_d   = txsh_q;
    ptr_d    = ptr_q;
    drive_d  = drive_q;
    mack_d   = mack_q;
    wr_en    = 1'b0;
    if (start || stop) begin
      phase_d  = start ? PH_DEV : PH_IDLE;
      in_ack_d = 1'b0;
      bitcnt_d = '0;
      drive_d  = 1'b0;
    end else begin
      case (phase_q)
        PH_DEV, PH_PTR, PH_WR: begin
          if (!in_ack_q) begin
            if (scl_rise && bitcnt_q != CW'(DW)) begin
              shreg_d  = {shreg_q[DW-2:0], sda_lvl};
              bitcnt_d = bitcnt_q + 1'b1;
            end
            if (scl_fall && bitcnt_q == CW'(DW)) begin
              in_ack_d = 1'b1;
              drive_d  = 1'b1;
              if (phase_q == PH_DEV) begin
                if (shreg_q[DW-1:1] != DEV_ADDR) begin
                  phase_d  = PH_SKIP;
                  in_ack_d = 1'b0;
                  drive_d  = 1'b0;
                end
              end else if (phase_q == PH_PTR) begin
                ptr_d = shreg_q[AW-1:0];
              end else begin
                wr_en = 1'b1;
                ptr_d = ptr_inc;
              end
            end
          end else if (scl_fall) begin
            in_ack_d = 1'b0;
            drive_d  = 1'b0;
            bitcnt_d = '0;
            if (phase_q == PH_DEV) begin
              if (shreg_q[0]) begin
                phase_d = PH_RD;
                txsh_d  = rd_data;
                drive_d = ~rd_data[DW-1];
              end else begin
                phase_d = PH_PTR;
              end
            end else begin
              phase_d = PH_WR;
            end
          end
        end
        PH_RD: begin
          if (!in_ack_q) begin
            if (scl_fall) begin
              if (bitcnt_q == CW'(DW - 1)) begin
                in_ack_d = 1'b1;
                drive_d  = 1'b0;
                ptr_d    = ptr_inc;
              end else begin
                bitcnt_d = bitcnt_q + 1'b1;
                txsh_d   = {txsh_q[DW-2:0], 1'b0};
                drive_d  = ~txsh_q[DW-2];
              end
            end
          end else begin
            if (scl_rise) mack_d = sda_lvl;
            if (scl_fall) begin
              in_ack_d = 1'b0;
              bitcnt_d = '0;
              if (!mack_q) begin
                txsh_d  = rd_data;
                drive_d = ~rd_data[DW-1];
              end else begin
                phase_d = PH_SKIP;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      in_ack_q <= 1'b0;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      txsh_q   <= '0;
      ptr_q    <= '0;
      drive_q  <= 1'b0;
      mack_q   <= 1'b1;
    end else begin
      phase_q  <= phase_d;
      in_ack_q <= in_ack_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      txsh_q   <= txsh_d;
      ptr_q    <= ptr_d;
      drive_q  <= drive_d;
      mack_q   <= mack_d;
    end
  end

  assign ptr       = ptr_q;
  assign wr_data   = shreg_q;
  assign sda_drive = drive_q;

  // R5: a stored byte advances the pointer by one, modulo the register count
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr_q == AW'((32'($past(ptr_q)) + 1) % NREG)));

  // R3: an acknowledge of the address byte only follows a matching address
  assert_ack_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DEV && in_ack_q) |-> (shreg_q[DW-1:1] == DEV_ADDR));

  // R3: while ignoring the bus, SDA is never pulled
  assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SKIP) |-> !drive_q);

  // R7: the master's acknowledge slot after a read byte is left free
  assert_read_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RD && in_ack_q) |-> !drive_q);

  // R10: no change of the SDA drive while SCL is high, barring bus conditions
  assert_oe_quiet_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && !start && !stop) |=> $stable(drive_q));
endmodule

// File: rtl/i2ct_top.sv
module i2ct_top #(
  parameter int DW   = 8,
  parameter int NREG = 16,
  parameter logic [DW-2:0] DEV_ADDR = 7'h1A,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [AW-1:0] lcl_addr,
  input  logic          lcl_we,
  input  logic [DW-1:0] lcl_wdata,
  output logic [DW-1:0] lcl_rdata
);
  logic [1:0]    rst_pipe;
  logic          rst_n_i;
  logic          scl_lvl, scl_rise, scl_fall;
  logic          sda_lvl, sda_rise, sda_fall;
  logic [AW-1:0] ptr;
  logic          wr_en;
  logic [DW-1:0] wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  i2ct_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n_i), .line_i(scl_i),
    .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall)
  );

  i2ct_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n_i), .line_i(sda_i),
    .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall)
  );

  i2ct_fsm #(.DW(DW), .NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n_i),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
    .sda_drive(sda_oe)
  );

  i2ct_regs #(.NREG(NREG), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n_i),
    .bus_we(wr_en), .bus_addr(ptr), .bus_wdata(wr_data), .bus_rdata(rd_data),
    .loc_we(lcl_we), .loc_addr(lcl_addr), .loc_wdata(lcl_wdata),
    .loc_rdata(lcl_rdata)
  );
endmodule

// File: tb/i2ct_top_bench.sv
module i2ct_top_bench;
  localparam int Q = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl, sda_m;
  logic       sda_oe;
  logic [3:0] lcl_addr;
  logic       lcl_we;
  logic [7:0] lcl_wdata, lcl_rdata;
  logic       sda_line;
  int         n_chk = 0;
  int         n_bad = 0;
  int         oe_hi_changes = 0;
  bit         done = 0;

  assign sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2ct_top u_i2ct_top (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .lcl_addr(lcl_addr), .lcl_we(lcl_we), .lcl_wdata(lcl_wdata),
    .lcl_rdata(lcl_rdata)
  );

  always @(sda_oe) if (rst_n === 1'b1 && scl === 1'b1) oe_hi_changes++;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; sda_m = 1'b0; #Q; scl = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #Q; scl = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; ack = sda_line; #Q; scl = 1'b0; #Q;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #Q; scl = 1'b1; #Q; d[i] = sda_line; #Q; scl = 1'b0; #Q;
    end
    sda_m = mack; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q; sda_m = 1'b1;
  endtask

  task automatic lcl_read(input logic [3:0] a, output logic [7:0] d);
    lcl_addr = a; #2; d = lcl_rdata;
  endtask

  task automatic lcl_write(input logic [3:0] a, input logic [7:0] d);
    lcl_addr = a; lcl_wdata = d; lcl_we = 1'b1; #5; lcl_we = 1'b0; #5;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 sda_oe", {7'd0, sda_oe}, 8'h00);
    lcl_read(4'h0, d); check("R1 reg0", d, 8'h00);
    lcl_read(4'hF, d); check("R1 reg15", d, 8'h00);
  endtask

  task automatic t_single_write();
    logic a; logic [7:0] d;
    bus_start();
    send_byte(8'h34, a); check("R3 addr ack", {7'd0, a}, 8'h00);
    send_byte(8'h03, a); check("R4 ptr ack", {7'd0, a}, 8'h00);
    send_byte(8'hA5, a); check("R5 data ack", {7'd0, a}, 8'h00);
    bus_stop();
    lcl_read(4'h3, d); check("R5 reg3", d, 8'hA5);
  endtask

  task automatic t_multi_wrap();
    logic a; logic [7:0] d;
    bus_start();
    send_byte(8'h34, a); send_byte(8'hFE, a);
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
    check("R5 last ack", {7'd0, a}, 8'h00);
    bus_stop();
    lcl_read(4'hE, d); check("R4 low bits reg14", d, 8'h11);
    lcl_read(4'hF, d); check("R5 reg15", d, 8'h22);
    lcl_read(4'h0, d); check("R5 wrap reg0", d, 8'h33);
  endtask

  task automatic t_current_read();
    logic a; logic [7:0] d;
    lcl_write(4'h1, 8'h5C);
    lcl_read(4'h1, d); check("R9 local write", d, 8'h5C);
    bus_start();
    send_byte(8'h35, a); check("R3 read addr ack", {7'd0, a}, 8'h00);
    recv_byte(1'b1, d); check("R6 current read", d, 8'h5C);
    bus_stop();
  endtask

  task automatic t_seq_read();
    logic a; logic [7:0] d;
    lcl_write(4'h2, 8'h12);
    bus_start();
    send_byte(8'h35, a);
    recv_byte(1'b0, d); check("R7 first byte", d, 8'h12);
    recv_byte(1'b1, d); check("R7 second byte", d, 8'hA5);
    #Q; check("R7 released after nack", {7'd0, sda_oe}, 8'h00);
    bus_stop();
  endtask

  task automatic t_mismatch();
    logic a; logic [7:0] d;
    bus_start();
    send_byte(8'h36, a); check("R3 no ack on mismatch", {7'd0, a}, 8'h01);
    send_byte(8'h00, a); check("R3 ignored byte no ack", {7'd0, a}, 8'h01);
    send_byte(8'h99, a);
    bus_stop();
    lcl_read(4'h0, d); check("R3 reg0 untouched", d, 8'h33);
    lcl_read(4'h4, d); check("R3 reg4 untouched", d, 8'h00);
  endtask

  task automatic t_stop_midbyte();
    logic a; logic [7:0] d;
    bus_start();
    send_byte(8'h34, a); send_byte(8'h06, a); send_byte(8'h66, a);
    send_bits(8'hF0, 4);
    bus_stop();
    lcl_read(4'h6, d); check("R5 reg6", d, 8'h66);
    lcl_read(4'h7, d); check("R2 partial byte dropped", d, 8'h00);
  endtask

  task automatic t_repeated_start();
    logic a; logic [7:0] d;
    lcl_write(4'h9, 8'h99);
    lcl_write(4'hA, 8'hC3);
    bus_start();
    send_byte(8'h34, a); send_byte(8'h08, a); send_byte(8'h77, a);
    bus_start();
    send_byte(8'h35, a); check("R8 ack after repeated start", {7'd0, a}, 8'h00);
    recv_byte(1'b1, d); check("R8 pointer kept", d, 8'h99);
    bus_stop();
    lcl_read(4'h8, d); check("R5 reg8", d, 8'h77);
    bus_start();
    send_byte(8'h35, a);
    recv_byte(1'b1, d); check("R6 pointer across stop", d, 8'hC3);
    bus_stop();
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1;
    lcl_addr = '0; lcl_we = 1'b0; lcl_wdata = '0;
    #21; rst_n = 1'b1; #40;
    t_reset();
    t_single_write();
    t_multi_wrap();
    t_current_read();
    t_seq_read();
    t_mismatch();
    t_stop_midbyte();
    t_repeated_start();
    check("R10 sda_oe change while SCL high", 8'(oe_hi_changes), 8'h00);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule